// File: doc/BRIEF.md
# Boolean Regulatory Network Stepper

This block holds the state of a three-entity Boolean regulatory network and advances it by one step each time a step strobe arrives. Every entity is a single bit: 1 when the entity is active (its gene expressed or its protein present) and 0 when it is inactive. The fixed update rules are: g1 copies g2, g2 becomes g1 AND g3, and g3 becomes NOT g1. Three entities give eight reachable state vectors.

Two update semantics are available. In synchronous mode every entity takes its new value from the same current vector in one step. In asynchronous mode a single entity, chosen by an index input, takes its new value and the other two keep theirs. A load strobe writes a starting vector. A flag shows in the same cycle whether the current vector is a fixed point of the rules. This lets a controller sweep initial conditions and schedules and watch for a stable state.

Top module: `bnet_stepper`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears the state vector to 000.
- R2: The state vector packs g1 in bit 2, g2 in bit 1 and g3 in bit 0. The next value of g1 is g2, of g2 is g1 AND g3, and of g3 is NOT g1. For example, 000 steps to 001 and 101 steps to 010.
- R3: With `async_mode` = 0, a step writes all three entities at one edge, each computed from the vector held before that edge.
- R4: With `async_mode` = 1, a step writes only the entity named by `ent_sel` (0 = g1, 1 = g2, 2 = g3) with its next value, and the other two bits keep their values.
- R5: With `async_mode` = 1 and `ent_sel` = 3, a step leaves the state vector unchanged.
- R6: When neither `load_en` nor `step_en` is high at an edge, the state vector holds.
- R7: When `load_en` is high at an edge, the state takes `load_val`, whatever `step_en`, `async_mode` and `ent_sel` are.
- R8: `fixed_pt` is high in exactly the cycles where every entity's next value equals its current value. For these rules, that is only the vector 001.
- R9: Stepping while in a fixed point leaves the state unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Write `load_val` into the state; takes priority over a step |
| load_val | input | 3 | Initial vector {g1,g2,g3} |
| async_mode | input | 1 | 0 = synchronous semantics, 1 = single-entity semantics |
| ent_sel | input | 2 | Entity to update in asynchronous mode (0 = g1, 1 = g2, 2 = g3, 3 = none) |
| step_en | input | 1 | Advance the network by one step |
| state_q | output | 3 | Current vector {g1,g2,g3} |
| fixed_pt | output | 1 | Current vector is a fixed point |

## Verification
The hardest behaviour to reach is asynchronous mode. Each step touches one bit, so a given transition can only be seen from the right start vector paired with the right index. Starting from the fixed point alone shows nothing. The stimulus therefore loads chosen vectors (101, 010, 110, 011) before each single-entity step, so that every index, including the unused one, produces a change or a hold that can be told apart. Same-cycle load-and-step collisions and a reset in the middle of a run are then driven directly.

// File: rtl/bnet_pkg.sv
// Shared definitions for the Boolean network stepper.
// Assumes a fixed three-entity network; the entity k occupies bit N_ENT-1-k.
package bnet_pkg;
    localparam int N_ENT = 3;
    localparam int SEL_W = $clog2(N_ENT + 1);
    typedef logic [N_ENT-1:0] bnet_state_t;
endpackage

// File: rtl/bnet_next.sv
// Next-state logic of the regulatory network.
// Purely combinational. Assumes the {g1,g2,g3} packing from bnet_pkg.
module bnet_next
    import bnet_pkg::*;
(
    input  bnet_state_t cur,
    output bnet_state_t nxt
);
    logic g1, g2, g3;

    // Split the vector into named entities.
    always_comb begin
        g1 = cur[2];
        g2 = cur[1];
        g3 = cur[0];
    end

    // Apply the regulation rules.
    always_comb begin
        nxt[2] = g2;
        nxt[1] = g1 & g3;
        nxt[0] = ~g1;
    end
endmodule

// File: rtl/bnet_update.sv
// Chooses which entities take their next value in a step.
// Synchronous semantics writes every bit. Asynchronous semantics writes only
// the bit picked by sel; an index with no entity writes nothing.
module bnet_update
    import bnet_pkg::*;
(
    input  bnet_state_t      cur,
    input  bnet_state_t      nxt,
    input  logic             async_mode,
    input  logic [SEL_W-1:0] sel,
    output bnet_state_t      upd
);
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        logic take;
        // Decide whether entity k is rewritten in this step.
        always_comb take = ~async_mode | (sel == SEL_W'(k));
        // Merge the next value or the held value for entity k.
        always_comb upd[N_ENT-1-k] = take ? nxt[N_ENT-1-k] : cur[N_ENT-1-k];
    end
endmodule

// File: rtl/bnet_stepper.sv
// Top of the Boolean network stepper: state register, load and step control,
// and fixed-point detection. Assumes synchronous active-low reset and that
// load takes priority over step in the same cycle.
module bnet_stepper
    import bnet_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [N_ENT-1:0] load_val,
    input  logic             async_mode,
    input  logic [SEL_W-1:0] ent_sel,
    input  logic             step_en,
    output logic [N_ENT-1:0] state_q,
    output logic             fixed_pt
);
    bnet_state_t st_q;
    bnet_state_t st_nxt;
    bnet_state_t st_upd;

    bnet_next u_next (
        .cur (st_q),
        .nxt (st_nxt)
    );

    bnet_update u_upd (
        .cur        (st_q),
        .nxt        (st_nxt),
        .async_mode (async_mode),
        .sel        (ent_sel),
        .upd        (st_upd)
    );

    // State register with reset, load priority, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else if (load_en)
            st_q <= load_val;
        else if (step_en)
            st_q <= st_upd;
    end

    // Drive the outputs from the held state.
    always_comb begin
        state_q  = st_q;
        fixed_pt = (st_nxt == st_q);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> state_q == '0);

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> state_q == $past(load_val));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> $stable(state_q));

    assert_async_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_en && async_mode) |=> $countones(state_q ^ $past(state_q)) <= 1);

    assert_async_bad_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_en && async_mode && ent_sel == 2'd3) |=> $stable(state_q));

    assert_fixed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_en && fixed_pt) |=> $stable(state_q));

    assert_sync_g3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_en && !async_mode) |=> state_q[0] == !$past(state_q[2]));
endmodule

// File: tb/bnet_stepper_tb_top.sv
`timescale 1ns/1ps
module bnet_stepper_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [2:0] load_val = 3'b000;
    logic       async_mode = 1'b0;
    logic [1:0] ent_sel = 2'd0;
    logic       step_en = 1'b0;
    logic [2:0] state_q;
    logic       fixed_pt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bnet_stepper dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
        .async_mode(async_mode), .ent_sel(ent_sel), .step_en(step_en),
        .state_q(state_q), .fixed_pt(fixed_pt)
    );

    // {start vector, async_mode, ent_sel, expected vector after one step}
    localparam int NV = 16;
    localparam logic [8:0] VEC [NV] = '{
        {3'b000, 1'b0, 2'd0, 3'b001},
        {3'b001, 1'b0, 2'd0, 3'b001},
        {3'b010, 1'b0, 2'd0, 3'b101},
        {3'b011, 1'b0, 2'd0, 3'b101},
        {3'b100, 1'b0, 2'd0, 3'b000},
        {3'b101, 1'b0, 2'd0, 3'b010},
        {3'b110, 1'b0, 2'd0, 3'b100},
        {3'b111, 1'b0, 2'd0, 3'b110},
        {3'b101, 1'b1, 2'd0, 3'b001},
        {3'b101, 1'b1, 2'd1, 3'b111},
        {3'b101, 1'b1, 2'd2, 3'b100},
        {3'b010, 1'b1, 2'd0, 3'b110},
        {3'b010, 1'b1, 2'd1, 3'b000},
        {3'b010, 1'b1, 2'd2, 3'b011},
        {3'b110, 1'b1, 2'd3, 3'b110},
        {3'b011, 1'b1, 2'd1, 3'b001}
    };

    task automatic check_state(input string req, input logic [2:0] exp);
        n_run++;
        if (state_q !== exp) begin
            n_fail++;
            $display("FAIL %s state actual=%b expected=%b", req, state_q, exp);
        end
    endtask

    task automatic check_fixed(input string req);
        logic e;
        e = (state_q == 3'b001);
        n_run++;
        if (fixed_pt !== e) begin
            n_fail++;
            $display("FAIL %s fixed_pt actual=%b expected=%b", req, fixed_pt, e);
        end
    endtask

    // Drive one cycle's inputs at the falling edge, then sample after the rising edge.
    task automatic cyc(input logic ld, input logic [2:0] lv, input logic st,
                       input logic am, input logic [1:0] sel);
        @(negedge clk);
        load_en = ld; load_val = lv; step_en = st; async_mode = am; ent_sel = sel;
        @(posedge clk);
        #1;
        load_en = 1'b0; step_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset clears the vector; 000 is not a fixed point (R8)
        cyc(1'b0, 3'b000, 1'b0, 1'b0, 2'd0);
        cyc(1'b0, 3'b000, 1'b0, 1'b0, 2'd0);
        check_state("R1", 3'b000);
        check_fixed("R8");
        @(negedge clk) rst_n = 1'b1;

        // R2 R3 R4 R5: table of single steps from loaded vectors
        for (int i = 0; i < NV; i++) begin
            cyc(1'b1, VEC[i][8:6], 1'b0, 1'b0, 2'd0);
            check_state("R7", VEC[i][8:6]);
            check_fixed("R8");
            cyc(1'b0, 3'b000, 1'b1, VEC[i][5], VEC[i][4:3]);
            check_state(VEC[i][5] ? (VEC[i][4:3] == 2'd3 ? "R5" : "R4") : "R3", VEC[i][2:0]);
        end

        // R6: no strobe, state holds over several cycles
        cyc(1'b1, 3'b110, 1'b0, 1'b0, 2'd0);
        cyc(1'b0, 3'b000, 1'b0, 1'b0, 2'd1);
        cyc(1'b0, 3'b000, 1'b0, 1'b1, 2'd2);
        check_state("R6", 3'b110);

        // R7: load overrides a step in the same cycle, both modes
        cyc(1'b1, 3'b111, 1'b1, 1'b0, 2'd0);
        check_state("R7", 3'b111);
        cyc(1'b1, 3'b010, 1'b1, 1'b1, 2'd1);
        check_state("R7", 3'b010);

        // R2 R3: repeated synchronous steps 010 -> 101 -> 010
        cyc(1'b0, 3'b000, 1'b1, 1'b0, 2'd0);
        check_state("R2", 3'b101);
        cyc(1'b0, 3'b000, 1'b1, 1'b0, 2'd0);
        check_state("R2", 3'b010);

        // R9: stepping at the fixed point keeps it, every mode and index
        cyc(1'b1, 3'b001, 1'b0, 1'b0, 2'd0);
        check_fixed("R8");
        cyc(1'b0, 3'b000, 1'b1, 1'b0, 2'd0);
        check_state("R9", 3'b001);
        for (int s = 0; s < 4; s++) begin
            cyc(1'b0, 3'b000, 1'b1, 1'b1, 2'(s));
            check_state("R9", 3'b001);
            check_fixed("R8");
        end

        // R1: reset in mid-run clears a loaded vector
        cyc(1'b1, 3'b110, 1'b0, 1'b0, 2'd0);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        check_state("R1", 3'b000);
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule